// File: doc/BRIEF.md
# Vector Lane Shifter with Narrowing Right Shifts

This block is a single lane of a vector shift unit. Each accepted operation takes one source operand, one shift amount and a selected element width, and returns one element result a clock later. Three single-width operations are offered: logical left, logical right and arithmetic right. Two narrowing operations read a source of twice the element width, shift it right (logically or arithmetically) and keep only the element-width low part. Narrowing therefore ends a widen-compute-narrow sequence without leaving the register width.

The shift amount comes from one of three places: the vector element, a scalar operand, or a small unsigned immediate. Only its low bits count. Single-width forms reduce the amount modulo the element width. Narrowing forms reduce it modulo twice the element width. Unsupported combinations raise an illegal flag and produce a zero result. These are unknown operation codes, an unknown amount source, and narrowing at the widest element size. Results narrower than the lane are zero-filled above the element width.

Top module: `vshift_lane`

## Requirements
- R1: While `rst` is high at a rising edge, the next state has `out_valid`, `illegal` and `result` all zero.
- R2: Every accepted input (`in_valid` high) yields `out_valid` high exactly one cycle later. With `in_valid` low, `out_valid` is low one cycle later and `result` keeps its previous value.
- R3: `result` bits at and above the element width are zero. When `illegal` is set, the whole `result` is zero.
- R4: `ew_code` selects the element width: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits.
- R5: `op` encodes 0 = logical left, 1 = logical right, 2 = arithmetic right, 4 = narrowing logical right, 5 = narrowing arithmetic right. Codes 3, 6 and 7 set `illegal`.
- R6: Single-width logical shifts act on the low element-width bits of `src`. They use the shift amount modulo the element width, and vacated positions are filled with zero.
- R7: The single-width arithmetic right shift fills vacated positions with `src` bit (element width − 1).
- R8: `amt_src` selects the amount: 0 = `vec_amt`, 1 = `scl_amt`, 2 = `imm_amt` zero-extended. Code 3 sets `illegal`.
- R9: The narrowing logical right shift takes the low 2×width bits of `src`, shifts them right with zero fill, and returns the low element-width bits.
- R10: The narrowing arithmetic right shift fills with `src` bit (2×width − 1).
- R11: Narrowing shifts use the shift amount modulo 2×width.
- R12: A narrowing op with `ew_code` = 3 sets `illegal` and gives a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| ew_code | input | 2 | Element width select |
| op | input | 3 | Operation select |
| amt_src | input | 2 | Shift amount source select |
| src | input | 64 | Source operand (double width for narrowing) |
| vec_amt | input | 64 | Amount from vector element |
| scl_amt | input | 64 | Amount from scalar operand |
| imm_amt | input | 5 | Unsigned immediate amount |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Element result, zero-padded |
| illegal | output | 1 | Unsupported operation flag |

## Verification
Amount reduction and sign fill can decide the same result bit in the same cycle. An arithmetic shift, single or narrowing, is given a negative source and a raw amount whose bits above the modulo boundary are set. If masking is wrong or uses the wrong width, the fill either covers the whole element or never appears. The bench drives such amounts and compares against a bit-by-bit reference model that picks every result bit from an explicit source index or the fill bit. Illegal detection and zero padding are checked in the same stream.

// File: rtl/vsh_pkg.sv
package vsh_pkg;
  typedef enum logic [2:0] {
    VSH_SLL  = 3'd0,
    VSH_SRL  = 3'd1,
    VSH_SRA  = 3'd2,
    VSH_NSRL = 3'd4,
    VSH_NSRA = 3'd5
  } vsh_op_e;

  typedef enum logic [1:0] {
    AMT_VEC = 2'd0,
    AMT_SCL = 2'd1,
    AMT_IMM = 2'd2
  } amt_src_e;
endpackage

// File: rtl/vsh_amt_pick.sv
module vsh_amt_pick #(
  parameter int XLEN  = 64,
  parameter int IMM_W = 5
) (
  input  logic [1:0]       amt_src,
  input  logic [XLEN-1:0]  vec_amt,
  input  logic [XLEN-1:0]  scl_amt,
  input  logic [IMM_W-1:0] imm_amt,
  output logic [XLEN-1:0]  amt,
  output logic             bad
);
  import vsh_pkg::*;

  always_comb begin
    amt = '0;
    bad = 1'b0;
    case (amt_src)
      AMT_VEC: amt = vec_amt;
      AMT_SCL: amt = scl_amt;
      AMT_IMM: amt = XLEN'(imm_amt);
      default: bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/vsh_width.sv
module vsh_width #(
  parameter int W    = 8,
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] src,
  input  logic [XLEN-1:0] amt,
  input  logic [2:0]      op,
  output logic [W-1:0]    res,
  output logic            bad
);
  import vsh_pkg::*;

  localparam int  ZS    = XLEN - W;
  localparam bit  HAS_N = (2 * W <= XLEN);

  logic [XLEN-1:0]        am_s;
  logic [XLEN-1:0]        zx;
  logic signed [XLEN-1:0] sx;
  logic [W-1:0]           sll_r, srl_r, sra_r, nsrl_r, nsra_r;

  // single-width: amount modulo W, source confined to W bits
  assign am_s  = amt & XLEN'(W - 1);
  assign zx    = (src << ZS) >> ZS;
  assign sx    = $signed(src << ZS) >>> ZS;
  assign sll_r = W'(src << am_s);
  assign srl_r = W'(zx >> am_s);
  assign sra_r = W'(sx >>> am_s);

  generate
    if (HAS_N) begin : g_nar
      localparam int NZ = XLEN - 2 * W;
      logic [XLEN-1:0]        am_n;
      logic [XLEN-1:0]        nzx;
      logic signed [XLEN-1:0] nsx;
      assign am_n   = amt & XLEN'(2 * W - 1);
      assign nzx    = (src << NZ) >> NZ;
      assign nsx    = $signed(src << NZ) >>> NZ;
      assign nsrl_r = W'(nzx >> am_n);
      assign nsra_r = W'(nsx >>> am_n);
    end else begin : g_no_nar
      assign nsrl_r = '0;
      assign nsra_r = '0;
    end
  endgenerate

  always_comb begin
    res = '0;
    bad = 1'b0;
    case (op)
      VSH_SLL:  res = sll_r;
      VSH_SRL:  res = srl_r;
      VSH_SRA:  res = sra_r;
      VSH_NSRL: begin res = nsrl_r; bad = !HAS_N; end
      VSH_NSRA: begin res = nsra_r; bad = !HAS_N; end
      default:  bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/vshift_lane.sv
module vshift_lane #(
  parameter int XLEN   = 64,
  parameter int MIN_EW = 8,
  parameter int IMM_W  = 5,
  parameter int NW     = $clog2(XLEN / MIN_EW) + 1,
  parameter int EWC_W  = $clog2(NW)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [EWC_W-1:0] ew_code,
  input  logic [2:0]       op,
  input  logic [1:0]       amt_src,
  input  logic [XLEN-1:0]  src,
  input  logic [XLEN-1:0]  vec_amt,
  input  logic [XLEN-1:0]  scl_amt,
  input  logic [IMM_W-1:0] imm_amt,
  output logic             out_valid,
  output logic [XLEN-1:0]  result,
  output logic             illegal
);
  logic [XLEN-1:0] amt;
  logic            bad_src;
  logic [XLEN-1:0] lane_res [NW];
  logic [NW-1:0]   lane_bad;
  logic [XLEN-1:0] sel_res;
  logic            bad_all;

  vsh_amt_pick #(.XLEN(XLEN), .IMM_W(IMM_W)) u_pick (
    .amt_src(amt_src), .vec_amt(vec_amt), .scl_amt(scl_amt),
    .imm_amt(imm_amt), .amt(amt), .bad(bad_src)
  );

  generate
    for (genvar g = 0; g < NW; g++) begin : g_w
      localparam int W = MIN_EW << g;
      logic [W-1:0] r;
      logic         b;
      vsh_width #(.W(W), .XLEN(XLEN)) u_w (
        .src(src), .amt(amt), .op(op), .res(r), .bad(b)
      );
      assign lane_res[g] = XLEN'(r);
      assign lane_bad[g] = b;
    end
  endgenerate

  always_comb begin
    sel_res = lane_res[ew_code];
    bad_all = bad_src | lane_bad[ew_code];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= bad_all ? '0 : sel_res;
        illegal <= bad_all;
      end
    end
  end
endmodule

// File: rtl/vshift_lane_chk.sv
module vshift_lane_chk #(
  parameter int XLEN   = 64,
  parameter int MIN_EW = 8,
  parameter int EWC_W  = 2,
  parameter int NW     = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [EWC_W-1:0] ew_code,
  input logic [2:0]       op,
  input logic [1:0]       amt_src,
  input logic             out_valid,
  input logic [XLEN-1:0]  result,
  input logic             illegal
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && !illegal && result == '0));

  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result)));

  assert_zero_pad_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ew_code == '0) |=> ((result >> MIN_EW) == '0));

  assert_illegal_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && illegal) |-> result == '0);

  assert_bad_opcode_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op == 3'd3 || op == 3'd6 || op == 3'd7)) |=> illegal);

  assert_bad_amt_src_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && amt_src == 2'd3) |=> illegal);

  assert_narrow_widest_R12: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ew_code == EWC_W'(NW - 1) && (op == 3'd4 || op == 3'd5))
    |=> (illegal && result == '0));
endmodule

bind vshift_lane vshift_lane_chk #(
  .XLEN(XLEN), .MIN_EW(MIN_EW), .EWC_W(EWC_W), .NW(NW)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .ew_code(ew_code), .op(op),
  .amt_src(amt_src), .out_valid(out_valid), .result(result), .illegal(illegal)
);

// File: tb/sim_vshift_lane.sv
module sim_vshift_lane;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  ew_code = '0;
  logic [2:0]  op = '0;
  logic [1:0]  amt_src = '0;
  logic [63:0] src = '0, vec_amt = '0, scl_amt = '0;
  logic [4:0]  imm_amt = '0;
  logic        out_valid;
  logic [63:0] result;
  logic        illegal;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [63:0] res;
    logic        ill;
    string       tag;
  } exp_t;
  exp_t q[$];
  logic [63:0] last_res = '0;

  always #2 clk = ~clk;

  vshift_lane u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .ew_code(ew_code), .op(op),
    .amt_src(amt_src), .src(src), .vec_amt(vec_amt), .scl_amt(scl_amt),
    .imm_amt(imm_amt), .out_valid(out_valid), .result(result), .illegal(illegal)
  );

  // bit-level reference built directly from the requirements
  function automatic exp_t model(logic [1:0] e, logic [2:0] o, logic [1:0] s,
                                 logic [63:0] a, logic [63:0] v, logic [63:0] c,
                                 logic [4:0] im);
    exp_t x;
    logic [63:0] raw;
    int w, ww, sh;
    x.res = '0; x.ill = 1'b0; x.tag = "";
    w = 8 << e;
    case (s)
      2'd0: raw = v;
      2'd1: raw = c;
      2'd2: raw = {59'd0, im};
      default: begin raw = '0; x.ill = 1'b1; end
    endcase
    if (o == 3'd3 || o > 3'd5) x.ill = 1'b1;
    if ((o == 3'd4 || o == 3'd5) && w == 64) x.ill = 1'b1;
    if (x.ill) return x;
    if (o <= 3'd2) begin
      sh = int'(raw % 64'(w));
      for (int i = 0; i < w; i++) begin
        if (o == 3'd0) x.res[i] = (i >= sh) ? a[i - sh] : 1'b0;
        else if (i + sh < w) x.res[i] = a[i + sh];
        else x.res[i] = (o == 3'd2) ? a[w - 1] : 1'b0;
      end
    end else begin
      ww = 2 * w;
      sh = int'(raw % 64'(ww));
      for (int i = 0; i < w; i++) begin
        if (i + sh < ww) x.res[i] = a[i + sh];
        else x.res[i] = (o == 3'd5) ? a[ww - 1] : 1'b0;
      end
    end
    return x;
  endfunction

  task automatic send(string tag, logic [1:0] e, logic [2:0] o, logic [1:0] s,
                      logic [63:0] a, logic [63:0] v, logic [63:0] c,
                      logic [4:0] im);
    exp_t x;
    @(negedge clk);
    in_valid = 1'b1; ew_code = e; op = o; amt_src = s;
    src = a; vec_amt = v; scl_amt = c; imm_amt = im;
    x = model(e, o, s, a, v, c, im);
    x.tag = tag;
    q.push_back(x);
    last_res = x.res;
  endtask

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pop expectations as results emerge
  always @(negedge clk) begin
    if (!rst && out_valid && !finished) begin
      if (q.size() == 0) begin
        check("R2 unexpected out_valid", 64'd1, 64'd0);
      end else begin
        exp_t x;
        x = q.pop_front();
        check(x.tag, result, x.res);
        check({x.tag, " illegal"}, {63'd0, illegal}, {63'd0, x.ill});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset out_valid", {63'd0, out_valid}, 64'd0);
    check("R1 reset result", result, 64'd0);
    check("R1 reset illegal", {63'd0, illegal}, 64'd0);
    rst = 1'b0;

    // R6 single-width logical shifts
    send("R6 sll e8", 2'd0, 3'd0, 2'd0, 64'hA5, 64'd3, 0, 0);
    send("R6 srl e16", 2'd1, 3'd1, 2'd0, 64'h0000_0000_0000_F00F, 64'd4, 0, 0);
    // R3 upper source bits ignored, zero pad
    send("R3 pad e8", 2'd0, 3'd0, 2'd0, 64'hFFFF_FFFF_FFFF_FF81, 64'd1, 0, 0);
    send("R3 pad e32", 2'd2, 3'd1, 2'd0, 64'hDEAD_BEEF_8000_0000, 64'd31, 0, 0);
    // R7 arithmetic right at element width
    send("R7 sra e32", 2'd2, 3'd2, 2'd0, 64'h1234_5678_8000_0010, 64'd4, 0, 0);
    send("R7 sra e64", 2'd3, 3'd2, 2'd0, 64'h8000_0000_0000_0000, 64'd63, 0, 0);
    send("R7 sra e16 pos", 2'd1, 3'd2, 2'd0, 64'hFFFF_FFFF_FFFF_7FFF, 64'd15, 0, 0);
    // R6 amount modulo element width, with sign fill (R7)
    send("R6 mod e8", 2'd0, 3'd0, 2'd0, 64'h01, 64'd11, 0, 0);
    send("R6 mod e64", 2'd3, 3'd1, 2'd0, 64'hF000_0000_0000_0000, 64'd70, 0, 0);
    send("R7 mod sra e8", 2'd0, 3'd2, 2'd0, 64'h80, 64'hFFFF_FFFF_FFFF_FFF9, 0, 0);
    // R8 amount source
    send("R8 scalar", 2'd2, 3'd0, 2'd1, 64'h1, 64'd9, 64'd17, 0);
    send("R8 imm", 2'd3, 3'd1, 2'd2, 64'h8000_0000_0000_0000, 64'd1, 64'd2, 5'd31);
    send("R8 bad src", 2'd1, 3'd0, 2'd3, 64'hFFFF, 64'd0, 0, 0);
    // R4 width codes on same operand
    for (int e = 0; e < 4; e++)
      send("R4 width", 2'(e), 3'd1, 2'd0, 64'hFEDC_BA98_7654_3210, 64'd4, 0, 0);
    // R9 / R10 / R11 narrowing
    send("R9 nsrl e8", 2'd0, 3'd4, 2'd0, 64'hBEEF, 64'd4, 0, 0);
    send("R9 nsrl e32", 2'd2, 3'd4, 2'd0, 64'hCAFE_F00D_1234_5678, 64'd32, 0, 0);
    send("R10 nsra e16", 2'd1, 3'd5, 2'd0, 64'h8000_1234, 64'd20, 0, 0);
    send("R10 nsra e32", 2'd2, 3'd5, 2'd0, 64'hF000_0000_0000_0000, 64'd60, 0, 0);
    send("R11 nmod e16", 2'd1, 3'd4, 2'd0, 64'h8765_4321, 64'd37, 0, 0);
    send("R11 nmod sra e32", 2'd2, 3'd5, 2'd0, 64'h8000_0000_0000_0002, 64'h41, 0, 0);
    // R12 / R5 illegal cases
    send("R12 nsrl e64", 2'd3, 3'd4, 2'd0, 64'hFFFF, 64'd1, 0, 0);
    send("R12 nsra e64", 2'd3, 3'd5, 2'd0, 64'hFFFF, 64'd1, 0, 0);
    send("R5 op3", 2'd0, 3'd3, 2'd0, 64'hFF, 64'd1, 0, 0);
    send("R5 op6", 2'd1, 3'd6, 2'd0, 64'hFF, 64'd1, 0, 0);
    send("R5 op7", 2'd2, 3'd7, 2'd0, 64'hFF, 64'd1, 0, 0);
    // mixed stream, all requirements
    for (int k = 0; k < 400; k++)
      send("R5 mixed", 2'($urandom), 3'($urandom), 2'($urandom % 3),
           {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
           5'($urandom));
    send("R6 final", 2'd1, 3'd0, 2'd0, 64'h0001, 64'd5, 0, 0);

    @(negedge clk);
    in_valid = 1'b0;
    src = '1; vec_amt = 64'd3;
    repeat (4) @(negedge clk);
    check("R2 queue drained", 64'(q.size()), 64'd0);
    check("R2 idle out_valid", {63'd0, out_valid}, 64'd0);
    check("R2 idle hold", result, last_res);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule